// File: doc/BRIEF.md
# Boot image loader

This block moves a boot image from external flash into on-chip RAM with no processor involved. A one-cycle `start` begins a load. The block first reads a fixed initial chunk of the image into a private staging buffer. From that buffer it decodes a 32-byte image header and the 16-byte boot record that follows it. The header sits at a fixed byte offset, and that offset depends on whether the image is marked execute-in-place (`xip_mode`).

If the header is valid, the staged words are copied to the target address named in the boot record. The flash is not read a second time for this part. Any part of the image beyond the staged chunk is then streamed from flash to RAM, directly after the copied part. The load ends with a one-cycle `done` pulse, which comes with the entry address and the two pointer words from the header. If the header is rejected, the load ends instead with a one-cycle error pulse and a code, and nothing has been written to RAM.

The flash side is a request/response port: one word-aligned byte address per request, and one 32-bit word per response. The RAM side is a valid/ready write port. All words are little-endian, so byte 0 of the image is bits 7:0 of the first flash word.

Top module: `boot_image_loader`

## Requirements
- R1: After `start`, the block reads the staging chunk from flash at ascending word addresses beginning at `FLASH_BASE`, one word per request. The chunk is 4 KB (1024 words) when `xip_mode` is 0 and 8 KB (2048 words) when it is 1.
- R2: The header is taken from image byte offset 0x400 when `xip_mode` is 0, and from offset 0x1000 when `xip_mode` is 1.
- R3: In the first header word, bits 7:0 must equal 0xD1. The length, formed with bits 15:8 as the most significant byte and bits 23:16 as the least significant byte, must equal 32. If either test fails, `err_valid` pulses with `err_code` = 1, no RAM write occurs and no further flash reads occur.
- R4: The words at header byte offsets +4, +12, +20 and +24 hold the entry address, the configuration pointer, the self address and the signature pointer. The boot record gives the start address at header +32 and the size in bytes at header +36. If the self address differs from start + header offset, `err_valid` pulses with `err_code` = 2 and no RAM write occurs. The R3 check takes priority over this one.
- R5: The first ceil(size/4) words, capped at the staging chunk, are written to RAM at start, start+4, and onward, in ascending order. They come from the staging buffer and are not read from flash again.
- R6: When ceil(size/4) exceeds the staging chunk, the remaining words are read from flash starting at `FLASH_BASE` + chunk bytes. Each is written to start + its image byte offset, in ascending order.
- R7: When the size fits in the staging chunk, the flash read count is exactly the chunk. A size of 0 produces no RAM writes at all.
- R8: `done` is a one-cycle pulse issued after the last write is accepted. While `done` is high, `entry_addr`, `cfg_ptr` and `sig_ptr` show the decoded header words. `err_valid` is also a single-cycle pulse and never coincides with `done`.
- R9: During and after reset the block is idle: `busy`, `rd_req_valid`, `wr_valid`, `done` and `err_valid` are all low.
- R10: `rd_req_valid` and `rd_addr` hold until `rd_req_ready` is seen. The write valid, address and data hold until `wr_ready` is seen. A flash request and a RAM write are never offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (taken when idle) |
| xip_mode | input | 1 | 1 selects the execute-in-place header offset and staging size |
| busy | output | 1 | A load is in progress |
| rd_req_valid | output | 1 | Flash read request valid |
| rd_req_ready | input | 1 | Flash accepts the request |
| rd_addr | output | ADDR_W | Flash byte address, word aligned |
| rd_rsp_valid | input | 1 | Flash read data valid (one cycle) |
| rd_rsp_data | input | 32 | Flash read data |
| wr_valid | output | 1 | RAM write valid |
| wr_ready | input | 1 | RAM accepts the write |
| wr_addr | output | ADDR_W | RAM byte address |
| wr_data | output | 32 | RAM write data |
| done | output | 1 | One-cycle load complete pulse |
| entry_addr | output | 32 | Decoded entry address |
| cfg_ptr | output | 32 | Decoded configuration pointer, passed through |
| sig_ptr | output | 32 | Decoded signature pointer, passed through |
| err_valid | output | 1 | One-cycle load error pulse |
| err_code | output | 2 | 1 = bad tag or length, 2 = self address mismatch |

## Verification
A wrong word counter or chunk-size choice appears on the flash port at once. The next read address breaks the ascending sequence, or the total read count differs from chunk plus remainder, and the count is known at the end of each load.

A wrong staging index or header field pointer corrupts either the data of the first RAM write or the error decision. The scoreboard catches both at the first accepted write, or at the end pulse, a few cycles after the header decode.

A swap of the length bytes, or an offset picked for the wrong mode, turns a good image into an error pulse and the reverse. This shows in the outcome of the load that exposes it.

// File: rtl/bl_pkg.sv
package bl_pkg;

    localparam int WORD_W = 32;

    localparam logic [7:0]  HDR_TAG      = 8'hD1;
    localparam logic [15:0] HDR_LEN      = 16'd32;

    // word positions relative to the header start
    localparam int FLD_HDR   = 0;
    localparam int FLD_ENTRY = 1;
    localparam int FLD_CFG   = 3;
    localparam int FLD_SELF  = 5;
    localparam int FLD_SIG   = 6;
    localparam int FLD_START = 8;
    localparam int FLD_SIZE  = 9;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STG_REQ,
        ST_STG_RSP,
        ST_HDR,
        ST_CHECK,
        ST_CPY,
        ST_FET_REQ,
        ST_FET_RSP,
        ST_FET_WR,
        ST_DONE,
        ST_ERR
    } ld_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_HDR  = 2'd1,
        ERR_SELF = 2'd2
    } ld_err_e;

    typedef struct packed {
        logic [WORD_W-1:0] hdr;
        logic [WORD_W-1:0] entry;
        logic [WORD_W-1:0] cfg;
        logic [WORD_W-1:0] self_addr;
        logic [WORD_W-1:0] sig;
        logic [WORD_W-1:0] start;
        logic [WORD_W-1:0] size;
    } img_hdr_t;

    function automatic logic [7:0] hdr_tag(input logic [WORD_W-1:0] w);
        return w[7:0];
    endfunction

    // length bytes are stored most significant first
    function automatic logic [15:0] hdr_len(input logic [WORD_W-1:0] w);
        return {w[15:8], w[23:16]};
    endfunction

endpackage

// File: rtl/bl_stage_ram.sv
module bl_stage_ram #(
    parameter int DEPTH = 2048,
    parameter int W     = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/bl_hdr_check.sv
module bl_hdr_check
    import bl_pkg::*;
(
    input  img_hdr_t          hdr,
    input  logic [WORD_W-1:0] hoff,
    output ld_err_e           err
);

    logic [WORD_W-1:0] self_exp;

    assign self_exp = hdr.start + hoff;

    // R3 outranks R4
    always_comb begin
        if (hdr_tag(hdr.hdr) != HDR_TAG || hdr_len(hdr.hdr) != HDR_LEN) begin
            err = ERR_HDR;
        end else if (hdr.self_addr != self_exp) begin
            err = ERR_SELF;
        end else begin
            err = ERR_NONE;
        end
    end

endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader
    import bl_pkg::*;
#(
    parameter int               ADDR_W          = 32,
    parameter int               STAGE_BYTES     = 4096,
    parameter int               STAGE_BYTES_XIP = 8192,
    parameter int               HOFF_PLAIN      = 'h400,
    parameter int               HOFF_XIP        = 'h1000,
    parameter logic [ADDR_W-1:0] FLASH_BASE     = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              xip_mode,
    output logic              busy,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rsp_valid,
    input  logic [31:0]       rd_rsp_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              done,
    output logic [31:0]       entry_addr,
    output logic [31:0]       cfg_ptr,
    output logic [31:0]       sig_ptr,
    output logic              err_valid,
    output logic [1:0]        err_code
);

    localparam int STG_W_PLAIN = STAGE_BYTES / 4;
    localparam int STG_W_XIP   = STAGE_BYTES_XIP / 4;
    localparam int DEPTH       = (STG_W_XIP > STG_W_PLAIN) ? STG_W_XIP : STG_W_PLAIN;
    localparam int SIDX_W      = $clog2(DEPTH);
    localparam int FLD_W       = 4;

    ld_state_e          state;
    ld_err_e            err_q;
    ld_err_e            chk_err;
    img_hdr_t           hdr_q;
    logic               xip_q;
    logic [ADDR_W-1:0]  widx;
    logic [ADDR_W-1:0]  total_w;
    logic [ADDR_W-1:0]  copy_w;
    logic [FLD_W-1:0]   fld;
    logic [WORD_W-1:0]  fet_q;

    logic [ADDR_W-1:0]  stage_w;
    logic [WORD_W-1:0]  hoff;
    logic [SIDX_W-1:0]  hbase;
    logic [SIDX_W-1:0]  ram_ridx;
    logic [WORD_W-1:0]  ram_rdata;
    logic               ram_we;
    logic [WORD_W:0]    size_ext;
    logic [ADDR_W-1:0]  size_words;
    logic [ADDR_W-1:0]  byte_off;

    // mode picks staging size and header position (R1, R2)
    assign stage_w  = xip_q ? ADDR_W'(STG_W_XIP) : ADDR_W'(STG_W_PLAIN);
    assign hoff     = xip_q ? WORD_W'(HOFF_XIP) : WORD_W'(HOFF_PLAIN);
    assign hbase    = hoff[SIDX_W+1:2];
    assign byte_off = widx << 2;

    // ceil(size / 4)
    assign size_ext   = {1'b0, hdr_q.size} + (WORD_W+1)'(3);
    assign size_words = ADDR_W'(size_ext[WORD_W:2]);

    assign ram_we   = (state == ST_STG_RSP) && rd_rsp_valid;
    assign ram_ridx = (state == ST_HDR) ? (hbase + SIDX_W'(fld)) : widx[SIDX_W-1:0];

    bl_stage_ram #(
        .DEPTH (DEPTH),
        .W     (WORD_W)
    ) u_stage (
        .clk     (clk),
        .we      (ram_we),
        .wr_idx  (widx[SIDX_W-1:0]),
        .wr_data (rd_rsp_data),
        .rd_idx  (ram_ridx),
        .rd_data (ram_rdata)
    );

    bl_hdr_check u_check (
        .hdr  (hdr_q),
        .hoff (hoff),
        .err  (chk_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            err_q   <= ERR_NONE;
            hdr_q   <= '0;
            xip_q   <= 1'b0;
            widx    <= '0;
            total_w <= '0;
            copy_w  <= '0;
            fld     <= '0;
            fet_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        xip_q <= xip_mode;
                        widx  <= '0;
                        state <= ST_STG_REQ;
                    end
                end
                ST_STG_REQ: begin
                    if (rd_req_ready) begin
                        state <= ST_STG_RSP;
                    end
                end
                ST_STG_RSP: begin
                    if (rd_rsp_valid) begin
                        if (widx == stage_w - 1'b1) begin
                            fld   <= '0;
                            state <= ST_HDR;
                        end else begin
                            widx  <= widx + 1'b1;
                            state <= ST_STG_REQ;
                        end
                    end
                end
                ST_HDR: begin
                    // one header word per cycle through the single read port
                    case (int'(fld))
                        FLD_HDR:   hdr_q.hdr       <= ram_rdata;
                        FLD_ENTRY: hdr_q.entry     <= ram_rdata;
                        FLD_CFG:   hdr_q.cfg       <= ram_rdata;
                        FLD_SELF:  hdr_q.self_addr <= ram_rdata;
                        FLD_SIG:   hdr_q.sig       <= ram_rdata;
                        FLD_START: hdr_q.start     <= ram_rdata;
                        FLD_SIZE:  hdr_q.size      <= ram_rdata;
                        default: ;
                    endcase
                    if (int'(fld) == FLD_SIZE) begin
                        state <= ST_CHECK;
                    end else begin
                        fld <= fld + 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (chk_err != ERR_NONE) begin
                        err_q <= chk_err;
                        state <= ST_ERR;
                    end else begin
                        err_q   <= ERR_NONE;
                        total_w <= size_words;
                        copy_w  <= (size_words > stage_w) ? stage_w : size_words;
                        widx    <= '0;
                        state   <= (size_words == '0) ? ST_DONE : ST_CPY;
                    end
                end
                ST_CPY: begin
                    if (wr_ready) begin
                        if (widx == copy_w - 1'b1) begin
                            if (total_w > copy_w) begin
                                widx  <= widx + 1'b1;
                                state <= ST_FET_REQ;
                            end else begin
                                state <= ST_DONE;
                            end
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                end
                ST_FET_REQ: begin
                    if (rd_req_ready) begin
                        state <= ST_FET_RSP;
                    end
                end
                ST_FET_RSP: begin
                    if (rd_rsp_valid) begin
                        fet_q <= rd_rsp_data;
                        state <= ST_FET_WR;
                    end
                end
                ST_FET_WR: begin
                    if (wr_ready) begin
                        if (widx == total_w - 1'b1) begin
                            state <= ST_DONE;
                        end else begin
                            widx  <= widx + 1'b1;
                            state <= ST_FET_REQ;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                ST_ERR:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state != ST_IDLE);
    assign rd_req_valid = (state == ST_STG_REQ) || (state == ST_FET_REQ);
    assign rd_addr      = FLASH_BASE + byte_off;
    assign wr_valid     = (state == ST_CPY) || (state == ST_FET_WR);
    assign wr_addr      = hdr_q.start[ADDR_W-1:0] + byte_off;
    assign wr_data      = (state == ST_CPY) ? ram_rdata : fet_q;
    assign done         = (state == ST_DONE);
    assign err_valid    = (state == ST_ERR);
    assign err_code     = err_q;
    assign entry_addr   = hdr_q.entry;
    assign cfg_ptr      = hdr_q.cfg;
    assign sig_ptr      = hdr_q.sig;

endmodule

// File: rtl/bl_loader_chk.sv
module bl_loader_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              done,
    input logic              err_valid,
    input logic [1:0]        err_code
);

    a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));

    a_r10_wr_hold: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    a_r10_port_excl: assert property (@(posedge clk) disable iff (rst)
        !(rd_req_valid && wr_valid));

    a_r5_wr_align: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> wr_addr[1:0] == 2'b00);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);

    a_r8_end_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err_valid}));

    a_r3_code_set: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> err_code != 2'd0);

    a_r9_quiet_after_end: assert property (@(posedge clk) disable iff (rst)
        done || err_valid |=> !wr_valid && !rd_req_valid);

endmodule

bind boot_image_loader bl_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_addr      (rd_addr),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .done         (done),
    .err_valid    (err_valid),
    .err_code     (err_code)
);

// File: tb/tb_boot_image_loader.sv
module tb_boot_image_loader;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] FBASE      = 32'h6000_0000;
    localparam int          FWORDS     = 4096;
    localparam int          WD_CYCLES  = 195000;

    logic        clk, rst, start, xip_mode, busy;
    logic        rd_req_valid, rd_req_ready, rd_rsp_valid;
    logic [31:0] rd_addr, rd_rsp_data;
    logic        wr_valid, wr_ready;
    logic [31:0] wr_addr, wr_data;
    logic        done, err_valid;
    logic [31:0] entry_addr, cfg_ptr, sig_ptr;
    logic [1:0]  err_code;

    boot_image_loader #(.FLASH_BASE(FBASE)) dut (
        .clk(clk), .rst(rst), .start(start), .xip_mode(xip_mode), .busy(busy),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .entry_addr(entry_addr), .cfg_ptr(cfg_ptr), .sig_ptr(sig_ptr),
        .err_valid(err_valid), .err_code(err_code)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        string       req;
    } wr_item_t;

    logic [31:0] fmem [FWORDS];
    wr_item_t    expq [$];
    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // flash model and write monitor (scoreboard side)
    initial begin
        int cyc = 0;
        bit pend = 0;
        int pidx = 0;
        bit rd_stall = 0;
        bit wr_stall = 0;
        logic [31:0] stall_a = '0, stall_wa = '0, stall_wd = '0;
        rd_rsp_valid = 1'b0; rd_rsp_data = '0; rd_req_ready = 1'b0; wr_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst && rd_stall)
                chk(rd_req_valid && rd_addr == stall_a, "R10", "read request held", rd_addr, stall_a);
            if (!rst && wr_stall)
                chk(wr_valid && wr_addr == stall_wa && wr_data == stall_wd, "R10",
                    "write held", wr_data, stall_wd);
            if (rd_rsp_valid) begin
                rd_rsp_valid = 1'b0;
            end else if (pend) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = fmem[pidx];
                pend = 0;
            end
            rd_req_ready = (cyc % 4) != 1;
            rd_stall = !rst && rd_req_valid && !rd_req_ready;
            stall_a  = rd_addr;
            if (!rst && rd_req_valid && rd_req_ready && !pend) begin
                chk(rd_addr == FBASE + 32'(4 * rd_cnt), "R1", "flash read address",
                    rd_addr, FBASE + 32'(4 * rd_cnt));
                pidx = int'((rd_addr - FBASE) >> 2) % FWORDS;
                pend = 1;
                rd_cnt++;
            end
            wr_ready = (cyc % 5) != 2;
            wr_stall = !rst && wr_valid && !wr_ready;
            stall_wa = wr_addr;
            stall_wd = wr_data;
            if (!rst && wr_valid && wr_ready) begin
                wr_item_t it;
                wr_cnt++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write", wr_addr, 32'd0);
                end else begin
                    it = expq.pop_front();
                    chk(wr_addr == it.a, it.req, "write address", wr_addr, it.a);
                    chk(wr_data == it.d, it.req, "write data", wr_data, it.d);
                end
            end
        end
    end

    // driver: builds the image, pushes expected writes, runs one load
    task automatic run_image(input bit xip, input int hpos, input logic [31:0] st,
                             input int size, input logic [31:0] entry,
                             input logic [31:0] cfg, input logic [31:0] sig,
                             input logic [7:0] tag, input logic [15:0] len,
                             input logic [31:0] self_delta, input int exp_err,
                             input string size_req);
        int w = hpos / 4;
        int stage = xip ? 2048 : 1024;
        int total = (size + 3) / 4;
        int exp_rd, exp_wr;
        for (int i = 0; i < FWORDS; i++)
            fmem[i] = {st[15:0] ^ 16'(i), 8'(i), 8'h3C};
        // R3: tag in bits 7:0, length MSB in bits 15:8, LSB in bits 23:16
        fmem[w]      = {8'h41, len[7:0], len[15:8], tag};
        fmem[w + 1]  = entry;
        fmem[w + 2]  = 32'd0;
        fmem[w + 3]  = cfg;
        fmem[w + 4]  = st + 32'(hpos) + 32'd32;
        fmem[w + 5]  = st + 32'(hpos) + self_delta;
        fmem[w + 6]  = sig;
        fmem[w + 7]  = 32'd0;
        fmem[w + 8]  = st;
        fmem[w + 9]  = 32'(size);
        fmem[w + 10] = 32'd0;
        fmem[w + 11] = 32'd0;
        if (exp_err == 0) begin
            for (int i = 0; i < total; i++) begin
                wr_item_t it;
                it.a = st + 32'(4 * i);
                it.d = fmem[i];
                it.req = (i < stage) ? "R5" : "R6";
                expq.push_back(it);
            end
        end
        exp_rd = (exp_err != 0 || total <= stage) ? stage : total;
        exp_wr = (exp_err != 0) ? 0 : total;
        rd_cnt = 0;
        wr_cnt = 0;
        xip_mode = xip;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(done || err_valid)) @(negedge clk);
        if (exp_err == 0) begin
            chk(done, "R8", "done pulse", 32'(done), 32'd1);
            chk(entry_addr == entry, "R8", "entry address", entry_addr, entry);
            chk(cfg_ptr == cfg, "R4", "configuration pointer", cfg_ptr, cfg);
            chk(sig_ptr == sig, "R4", "signature pointer", sig_ptr, sig);
        end else begin
            chk(err_valid, exp_err == 1 ? "R3" : "R4", "error pulse", 32'(err_valid), 32'd1);
            chk(32'(err_code) == 32'(exp_err), exp_err == 1 ? "R3" : "R4", "error code",
                32'(err_code), 32'(exp_err));
        end
        @(negedge clk);
        chk(!done && !err_valid, "R8", "end pulse one cycle", 32'({done, err_valid}), 32'd0);
        chk(rd_cnt == exp_rd, size_req, "flash read count", 32'(rd_cnt), 32'(exp_rd));
        chk(wr_cnt == exp_wr, size_req, "RAM write count", 32'(wr_cnt), 32'(exp_wr));
        chk(expq.size() == 0, size_req, "writes left over", 32'(expq.size()), 32'd0);
        expq.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; xip_mode = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && !rd_req_valid && !wr_valid && !done && !err_valid, "R9",
            "idle in reset", 32'({busy, rd_req_valid, wr_valid, done, err_valid}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !rd_req_valid && !wr_valid && !done && !err_valid, "R9",
            "idle after reset", 32'({busy, rd_req_valid, wr_valid, done, err_valid}), 32'd0);

        // R6: plain image with a streamed remainder
        run_image(0, 'h400, 32'h0000_8000, 'h1800, 32'h0000_A0D1, 32'h0, 32'h1234,
                  8'hD1, 16'd32, 32'h400 - 32'h400, 0, "R6");
        // R2: XIP offset, 8 KB chunk, remainder streamed
        run_image(1, 'h1000, 32'h0002_0000, 'h3000, 32'h0002_2401, 32'h0002_0040, 32'h0,
                  8'hD1, 16'd32, 32'd0, 0, "R6");
        // R7: small image, only the chunk is read
        run_image(0, 'h400, 32'h2000_0000, 'h100, 32'h2000_2001, 32'h0, 32'h0,
                  8'hD1, 16'd32, 32'd0, 0, "R7");
        // R6: size not a word multiple rounds up to one extra fetched word
        run_image(0, 'h400, 32'h0001_0000, 'h1002, 32'h0001_2001, 32'h0, 32'h0,
                  8'hD1, 16'd32, 32'd0, 0, "R6");
        // R7: size exactly the chunk
        run_image(0, 'h400, 32'h0000_4000, 'h1000, 32'h0000_6001, 32'h0, 32'h0,
                  8'hD1, 16'd32, 32'd0, 0, "R7");
        // R7: zero size, no writes
        run_image(0, 'h400, 32'h0000_4000, 0, 32'h0000_6001, 32'h0, 32'h0,
                  8'hD1, 16'd32, 32'd0, 0, "R7");
        // R7: XIP image shorter than the chunk
        run_image(1, 'h1000, 32'h0003_0000, 'h1400, 32'h0003_2001, 32'h0, 32'h55,
                  8'hD1, 16'd32, 32'd0, 0, "R7");
        // R3: wrong tag
        run_image(0, 'h400, 32'h0000_8000, 'h1800, 32'h0, 32'h0, 32'h0,
                  8'hD2, 16'd32, 32'd0, 1, "R3");
        // R3: length stored in the wrong byte order
        run_image(0, 'h400, 32'h0000_8000, 'h1800, 32'h0, 32'h0, 32'h0,
                  8'hD1, 16'h2000, 32'd0, 1, "R3");
        // R4: self address off by 4
        run_image(0, 'h400, 32'h0000_8000, 'h1800, 32'h0, 32'h0, 32'h0,
                  8'hD1, 16'd32, 32'd4, 2, "R4");
        // R2: header placed for plain mode but XIP selected
        run_image(1, 'h400, 32'h0000_8000, 'h1800, 32'h0, 32'h0, 32'h0,
                  8'hD1, 16'd32, 32'd0, 1, "R2");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule